// File: doc/BRIEF.md
# BCH Error Location Mapper

This block sits after a BCH error locator on the read path of a NAND flash controller. For one 512-byte sector, it receives the list of error bit locations that the locator found. It turns each location into a correction command that a buffer-patching stage downstream can apply. A location is counted backwards from the end of a combined span made of the data bytes followed by the used ECC bytes. Each location therefore maps to one of three results: a bit flip in the data area, a bit flip in the stored ECC bytes, or an invalid location.

A job is launched by pulsing `start` while `busy` is low. The pulse carries the correction mode, the error count, the packed location list and two summary flags: the computed syndrome is all zero, or the stored ECC is all 0xFF. When either flag is set, the sector is treated as clean or erased and no command is produced. Otherwise the block walks the list, one location per cycle. It offers each flip on a valid/ready command port. At the end it pulses `done`, together with the number of flips issued and an error flag.

Back-pressure rules on the command port:
- Once `cmd_valid` is high, it stays high and the command fields stay unchanged until a cycle in which `cmd_ready` is high.
- A command is transferred on every rising edge where both `cmd_valid` and `cmd_ready` are high.
- `cmd_valid` never depends on `cmd_ready`.

Top module: `bch_loc_mapper`

## Requirements
- R1: While reset is held and directly after it, `cmd_valid`, `done` and `busy` are low.
- R2: `mode16`=0 selects 8-bit correction, where 13 ECC bytes are used (the 14th is reserved) and the span limit is 525. `mode16`=1 selects 16-bit correction, with 26 ECC bytes and a limit of 538. For location L, the byte position is limit − 1 − floor(L/8) and the bit index is L mod 8.
- R3: A byte position below 512 yields a command with `cmd_to_ecc`=0, `cmd_byte` equal to the position and `cmd_bit` equal to L mod 8.
- R4: A byte position from 512 up to limit − 1 yields a command with `cmd_to_ecc`=1, `cmd_byte` equal to the position − 512 and `cmd_bit` equal to L mod 8.
- R5: A location with floor(L/8) ≥ limit issues no command and sets `done_err`. The locations after it are still processed.
- R6: With `syn_zero`=1 at start, no command is issued and `done` reports a count of 0 and `done_err`=0.
- R7: With `ecc_erased`=1 at start, no command is issued and `done` reports a count of 0 and `done_err`=0.
- R8: A count above 8 in mode 0, or above 16 in mode 1, issues no command and reports a count of 0 and `done_err`=1.
- R9: Commands leave in list order, starting with entry 0, which sits in bits [12:0] of `loc_list`. A command stays valid and unchanged until it is accepted.
- R10: `done` is a one-cycle pulse. `done_cnt` equals the number of commands accepted, and `busy` is high from the cycle after `start` through the `done` cycle. A `start` pulse while `busy` is high is ignored.
- R11: An error count of 0 with both flags low ends with a count of 0, `done_err`=0 and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a job; taken only when `busy` is low |
| mode16 | input | 1 | 0: 8-bit correction, 1: 16-bit correction |
| err_cnt | input | 5 | Number of valid entries in `loc_list` |
| loc_list | input | 208 | 16 packed 13-bit locations, entry i at [13i+12:13i] |
| syn_zero | input | 1 | Computed syndrome is all zero |
| ecc_erased | input | 1 | Stored ECC bytes are all 0xFF |
| busy | output | 1 | A job is in progress |
| cmd_valid | output | 1 | Flip command offered |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_to_ecc | output | 1 | 0: data byte target, 1: ECC byte target |
| cmd_byte | output | 9 | Byte index within the selected area |
| cmd_bit | output | 3 | Bit index within the byte |
| done | output | 1 | One-cycle completion pulse |
| done_cnt | output | 5 | Commands issued in the finished job |
| done_err | output | 1 | Invalid location or excess count seen |

## Verification
The hardest case to reach from the ports is an invalid location placed between valid ones while the command port is stalled. Here the scan must skip an entry without emitting anything, hold the pending flip and still keep list order. The stimulus sweeps every possible 13-bit location value through full-length lists in both modes, so each list mixes data, ECC and out-of-span entries. A ready pattern is applied that drops `cmd_ready` on roughly one cycle in five. A second `start` is injected in the middle of one job to show that it leaves the stream untouched.

// File: rtl/bch_map_pkg.sv
package bch_map_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } map_state_t;

  typedef struct packed {
    logic       ok;
    logic       to_ecc;
    logic [8:0] byte_idx;
    logic [2:0] bit_idx;
  } flip_t;
endpackage

// File: rtl/bch_loc_decode.sv
module bch_loc_decode #(
  parameter int DATA_BYTES = 512,
  parameter int ECC8_USED  = 13,
  parameter int ECC16_USED = 26,
  parameter int LOC_W      = 13,
  parameter int BYTE_W     = 9
) (
  input  logic              mode16,
  input  logic [LOC_W-1:0]  loc,
  output logic              ok,
  output logic              to_ecc,
  output logic [BYTE_W-1:0] byte_idx,
  output logic [2:0]        bit_idx
);
  localparam int CW = LOC_W + 1;

  logic [CW-1:0] lim;
  logic [CW-1:0] q;
  logic [CW-1:0] pos;
  logic [CW-1:0] rel;

  always_comb begin
    lim      = mode16 ? CW'(DATA_BYTES + ECC16_USED) : CW'(DATA_BYTES + ECC8_USED);
    q        = CW'(loc[LOC_W-1:3]);
    ok       = (q < lim);
    pos      = lim - CW'(1) - q;
    to_ecc   = (pos >= CW'(DATA_BYTES));
    rel      = to_ecc ? (pos - CW'(DATA_BYTES)) : pos;
    byte_idx = ok ? rel[BYTE_W-1:0] : '0;
    bit_idx  = loc[2:0];
  end
endmodule

// File: rtl/bch_map_ctrl.sv
module bch_map_ctrl
  import bch_map_pkg::*;
#(
  parameter int MAX_ERR = 16,
  parameter int T8      = 8,
  parameter int T16     = 16,
  parameter int LOC_W   = 13,
  parameter int CNT_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     mode16,
  input  logic [CNT_W-1:0]         err_cnt,
  input  logic [MAX_ERR*LOC_W-1:0] loc_list,
  input  logic                     syn_zero,
  input  logic                     ecc_erased,
  input  logic                     loc_ok,
  input  logic                     cmd_ready,
  output logic                     mode16_q,
  output logic [LOC_W-1:0]         cur_loc,
  output logic                     scanning,
  output logic                     busy,
  output logic                     done,
  output logic [CNT_W-1:0]         done_cnt,
  output logic                     done_err
);
  localparam int IDX_W = $clog2(MAX_ERR);

  map_state_t               st;
  logic [MAX_ERR*LOC_W-1:0] list_q;
  logic [LOC_W-1:0]         loc_arr [MAX_ERR];
  logic [CNT_W-1:0]         cnt_q;
  logic [IDX_W-1:0]         idx;
  logic [CNT_W-1:0]         cnt_lim;
  logic                     last;
  logic                     step;

  for (genvar g = 0; g < MAX_ERR; g++) begin : g_unpack
    assign loc_arr[g] = list_q[g*LOC_W +: LOC_W];
  end

  assign cur_loc  = loc_arr[idx];
  assign scanning = (st == ST_SCAN);
  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_FIN);
  assign cnt_lim  = mode16 ? CNT_W'(T16) : CNT_W'(T8);
  assign last     = (CNT_W'(idx) == cnt_q - CNT_W'(1));
  assign step     = scanning && (!loc_ok || cmd_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      list_q   <= '0;
      cnt_q    <= '0;
      idx      <= '0;
      mode16_q <= 1'b0;
      done_cnt <= '0;
      done_err <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          mode16_q <= mode16;
          list_q   <= loc_list;
          cnt_q    <= err_cnt;
          idx      <= '0;
          done_cnt <= '0;
          done_err <= 1'b0;
          if (syn_zero || ecc_erased || err_cnt == '0) begin
            st <= ST_FIN;
          end else if (err_cnt > cnt_lim) begin
            done_err <= 1'b1;
            st       <= ST_FIN;
          end else begin
            st <= ST_SCAN;
          end
        end
        ST_SCAN: if (step) begin
          if (!loc_ok) done_err <= 1'b1;
          else         done_cnt <= done_cnt + CNT_W'(1);
          if (last) st  <= ST_FIN;
          else      idx <= idx + IDX_W'(1);
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  fixed_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_cnt <= cnt_q);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(mode16_q) && $stable(cnt_q));
endmodule

// File: rtl/bch_loc_mapper.sv
module bch_loc_mapper
  import bch_map_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int ECC8_USED  = 13,
  parameter int ECC16_USED = 26,
  parameter int T8         = 8,
  parameter int T16        = 16,
  parameter int MAX_ERR    = 16,
  parameter int LOC_W      = 13,
  parameter int CNT_W      = 5,
  parameter int BYTE_W     = $clog2(DATA_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     mode16,
  input  logic [CNT_W-1:0]         err_cnt,
  input  logic [MAX_ERR*LOC_W-1:0] loc_list,
  input  logic                     syn_zero,
  input  logic                     ecc_erased,
  output logic                     busy,
  output logic                     cmd_valid,
  input  logic                     cmd_ready,
  output logic                     cmd_to_ecc,
  output logic [BYTE_W-1:0]        cmd_byte,
  output logic [2:0]               cmd_bit,
  output logic                     done,
  output logic [CNT_W-1:0]         done_cnt,
  output logic                     done_err
);
  logic             mode16_q;
  logic [LOC_W-1:0] cur_loc;
  logic             scanning;
  logic             loc_ok;

  bch_map_ctrl #(
    .MAX_ERR(MAX_ERR), .T8(T8), .T16(T16), .LOC_W(LOC_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode16(mode16),
    .err_cnt(err_cnt), .loc_list(loc_list), .syn_zero(syn_zero),
    .ecc_erased(ecc_erased), .loc_ok(loc_ok), .cmd_ready(cmd_ready),
    .mode16_q(mode16_q), .cur_loc(cur_loc), .scanning(scanning),
    .busy(busy), .done(done), .done_cnt(done_cnt), .done_err(done_err)
  );

  bch_loc_decode #(
    .DATA_BYTES(DATA_BYTES), .ECC8_USED(ECC8_USED), .ECC16_USED(ECC16_USED),
    .LOC_W(LOC_W), .BYTE_W(BYTE_W)
  ) u_dec (
    .mode16(mode16_q), .loc(cur_loc), .ok(loc_ok), .to_ecc(cmd_to_ecc),
    .byte_idx(cmd_byte), .bit_idx(cmd_bit)
  );

  assign cmd_valid = scanning && loc_ok;

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_to_ecc)
      && $stable(cmd_byte) && $stable(cmd_bit));

  // R4
  ecc_byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_to_ecc |->
      cmd_byte < (mode16_q ? BYTE_W'(ECC16_USED) : BYTE_W'(ECC8_USED)));

  // R5
  no_cmd_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !done);
endmodule

// File: tb/test_bch_loc_mapper.sv
module test_bch_loc_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NLOC = 16;
  localparam int LW = 13;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode16 = 1'b0;
  logic [4:0] err_cnt = '0;
  logic [NLOC*LW-1:0] loc_list = '0;
  logic syn_zero = 1'b0;
  logic ecc_erased = 1'b0;
  logic cmd_ready = 1'b0;
  logic busy, cmd_valid, cmd_to_ecc, done, done_err;
  logic [8:0] cmd_byte;
  logic [2:0] cmd_bit;
  logic [4:0] done_cnt;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bch_loc_mapper i_bch_loc_mapper (
    .clk(clk), .rst_n(rst_n), .start(start), .mode16(mode16),
    .err_cnt(err_cnt), .loc_list(loc_list), .syn_zero(syn_zero),
    .ecc_erased(ecc_erased), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_to_ecc(cmd_to_ecc), .cmd_byte(cmd_byte),
    .cmd_bit(cmd_bit), .done(done), .done_cnt(done_cnt), .done_err(done_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors = vectors + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one job and checks the full command stream against arithmetic expectations.
  task automatic run_job(input logic m, input int cnt, input logic sz, input logic er,
                         input int seed, input bit poke);
    int exp_valid [NLOC];
    int exp_ecc [NLOC];
    int exp_byte [NLOC];
    int exp_bit [NLOC];
    int n_exp = 0;
    int k = 0;
    int waitc = 0;
    int lim = m ? 538 : 525;
    int maxc = m ? 16 : 8;
    bit exp_err = 0;
    bit quiet = sz || er || (cnt == 0);
    bit over = !quiet && (cnt > maxc);
    for (int i = 0; i < NLOC; i++) begin
      int l = int'(loc_list[i*LW +: LW]);
      int q = l / 8;
      int pos = lim - 1 - q;
      if (i < cnt && !quiet && !over) begin
        if (q >= lim) exp_err = 1;
        else begin
          exp_ecc[n_exp]  = (pos >= 512) ? 1 : 0;
          exp_byte[n_exp] = (pos >= 512) ? pos - 512 : pos;
          exp_bit[n_exp]  = l % 8;
          n_exp++;
        end
      end
      exp_valid[i] = 0;
    end
    if (over) exp_err = 1;
    @(negedge clk);
    mode16 = m; err_cnt = 5'(cnt); syn_zero = sz; ecc_erased = er; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10: busy is high from the cycle after start
    if (poke) chk("R10 busy after start", int'(busy), 1);
    forever begin
      if (poke && waitc == 2) begin
        start = 1'b1; mode16 = ~m; syn_zero = 1'b1; err_cnt = 5'd1;
      end else if (poke && waitc == 3) begin
        start = 1'b0;
      end
      if (done) break;
      if (cmd_valid) begin
        if (k >= n_exp) begin
          chk("R5/R6/R7/R8 unexpected command", k, n_exp - 1);
          k++;
        end else begin
          string rq = exp_ecc[k] ? "R4" : "R3";
          vectors++;
          if (int'(cmd_to_ecc) != exp_ecc[k] || int'(cmd_byte) != exp_byte[k]
              || int'(cmd_bit) != exp_bit[k]) begin
            fails++;
            $display("FAIL %s/R2/R9 cmd %0d: actual ecc=%0d byte=%0d bit=%0d expected ecc=%0d byte=%0d bit=%0d",
                     rq, k, cmd_to_ecc, cmd_byte, cmd_bit, exp_ecc[k], exp_byte[k], exp_bit[k]);
          end
        end
      end
      cmd_ready = (((cyc * 7) + seed) % 5) != 0;
      if (cmd_valid && cmd_ready) k++;
      waitc++;
      if (waitc > 200) break;
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    chk("R10 done seen", int'(done), 1);
    chk("R10 commands accepted", k, n_exp);
    chk("R10 done_cnt", int'(done_cnt), n_exp);
    chk(over ? "R8 done_err" : (quiet ? "R6/R7/R11 done_err" : "R5 done_err"),
        int'(done_err), int'(exp_err));
    @(negedge clk);
    chk("R10 done one cycle", int'(done), 0);
    chk("R10 idle after done", int'(busy), 0);
    for (int i = 0; i < NLOC; i++) exp_valid[i] = exp_valid[i];
  endtask

  task automatic fill(input int base, input int stride);
    for (int i = 0; i < NLOC; i++)
      loc_list[i*LW +: LW] = LW'((base + i * stride) % 8192);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cmd_valid in reset", int'(cmd_valid), 0);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    // R2 R3 R4 R5: every 13-bit location in both modes
    for (int j = 0; j < 1024; j++) begin
      fill(j * 8, 1);
      run_job(1'b0, 8, 1'b0, 1'b0, j, 1'b0);
    end
    for (int j = 0; j < 512; j++) begin
      fill(j * 16, 1);
      run_job(1'b1, 16, 1'b0, 1'b0, j, 1'b0);
    end
    // R5: invalid entries interleaved with valid ones
    for (int j = 0; j < 64; j++) begin
      fill(j * 37, 523);
      run_job(j[0], j[0] ? 16 : 8, 1'b0, 1'b0, j, 1'b0);
    end
    // Boundary locations: last data byte, first ECC byte, last ECC byte, first invalid
    loc_list = '0;
    loc_list[0*LW +: LW] = 13'(8 * 13 + 5);
    loc_list[1*LW +: LW] = 13'(8 * 12 + 2);
    loc_list[2*LW +: LW] = 13'(8 * 0 + 7);
    loc_list[3*LW +: LW] = 13'(8 * 525);
    loc_list[4*LW +: LW] = 13'(8 * 524 + 1);
    run_job(1'b0, 5, 1'b0, 1'b0, 3, 1'b0);
    run_job(1'b1, 5, 1'b0, 1'b0, 4, 1'b0);
    // R6, R7
    fill(5, 3);
    run_job(1'b0, 4, 1'b1, 1'b0, 0, 1'b0);
    run_job(1'b1, 4, 1'b0, 1'b1, 0, 1'b0);
    run_job(1'b1, 4, 1'b1, 1'b1, 0, 1'b0);
    // R8: counts above the mode limit
    run_job(1'b0, 9, 1'b0, 1'b0, 0, 1'b0);
    run_job(1'b1, 17, 1'b0, 1'b0, 0, 1'b0);
    run_job(1'b0, 31, 1'b0, 1'b0, 0, 1'b0);
    run_job(1'b1, 16, 1'b0, 1'b0, 1, 1'b0);
    // R11
    run_job(1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    // R10: start while busy ignored
    fill(40, 8);
    run_job(1'b0, 8, 1'b0, 1'b0, 2, 1'b1);
    run_job(1'b1, 12, 1'b0, 1'b0, 1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule